// File: doc/BRIEF.md
# Transmit Descriptor Frame Assembler

This block turns a stream of transmit descriptors into finished byte frames. Each descriptor carries a 64-bit control word and a 64-bit buffer address. The block reads the described buffer one byte at a time over a simple request/response memory port and appends those bytes to a frame held in an internal store. The first descriptor of a frame has its start bit set and the last has its end bit set, so one frame may gather bytes from several buffers.

When the first descriptor of a frame asks for it, a 16-bit ones'-complement checksum is accumulated while the bytes arrive. The checksum covers everything from a start offset to the end of the frame and is written into the stored frame at a second offset before any byte leaves. The frame then goes out on a byte-wide AXI4-Stream master. A no-CRC flag from the first descriptor travels with every beat on the user sideband. Descriptors that request it produce a one-cycle interrupt pulse. A descriptor that breaks start/end framing produces a one-cycle error pulse and is thrown away.

Top module: `txd_frame_asm`

## Requirements
- R1: Control word bits 14:0 give a descriptor's byte count. A descriptor with both bit 31 (start) and bit 30 (end) set yields one frame of exactly that many bytes, read from consecutive addresses starting at the buffer address and sent in address order, with tlast high on the final beat only.
- R2: A frame spanning several descriptors, from the one with bit 31 to the one with bit 30, carries the bytes of each descriptor in the order the descriptors were accepted.
- R3: When bit 29 of the first descriptor is set, bits 20:15 give a start offset S and bits 28:21 give a stuff offset T, both counted in bytes from the frame start. Bytes from S to the frame end are summed as 16-bit big-endian words, with the byte at S as a high byte and a trailing odd byte as a high byte. The sum is folded with end-around carry and complemented, and the result is stored with its high byte at T and its low byte at T+1. When bit 29 is clear, the frame is sent exactly as read.
- R4: A stuff position at or beyond the frame length is not written, and the frame length never changes because of insertion.
- R5: Bit 32 of a descriptor gives exactly one one-cycle irq pulse after that descriptor's bytes have been read. A descriptor with bit 32 clear gives none.
- R6: Bit 33 of a frame's first descriptor is driven on tuser for every beat of that frame. Bit 33 of later descriptors in the same frame is ignored.
- R7: A descriptor without bit 31 while no frame is open, or with bit 31 while a frame is open, gives a one-cycle frame_err pulse. It is dropped without any memory read, and any open frame carries on unchanged.
- R8: A zero-length descriptor reads no memory and adds no bytes, but its start and end bits still frame. A frame whose descriptors are all zero-length emits no beats.
- R9: While tvalid is high and tready is low, tdata, tlast and tuser hold. No descriptor is accepted while a frame is being sent.
- R10: After reset, tvalid, irq, frame_err and mem_rd_en are low and desc_ready is high.
- R11: The memory port has at most one read outstanding, and exactly one read is issued for each byte of each accepted descriptor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| desc_valid | input | 1 | Descriptor offered |
| desc_ready | output | 1 | Descriptor accepted this cycle when valid |
| desc_ctrl | input | 64 | Descriptor control word |
| desc_addr | input | ADDR_W | Descriptor buffer byte address |
| mem_rd_en | output | 1 | One-cycle byte read request |
| mem_rd_addr | output | ADDR_W | Byte address of the request |
| mem_rd_valid | input | 1 | Read data returned |
| mem_rd_data | input | 8 | Returned byte |
| m_axis_tvalid | output | 1 | Stream beat valid |
| m_axis_tready | input | 1 | Stream sink ready |
| m_axis_tdata | output | 8 | Frame byte |
| m_axis_tlast | output | 1 | Final byte of frame |
| m_axis_tuser | output | 1 | No-CRC flag of the frame |
| irq | output | 1 | Descriptor completion interrupt pulse |
| frame_err | output | 1 | Framing error pulse for a dropped descriptor |

## Verification
A wrong write pointer or a lost open-frame flag shows up at the end of the frame as a wrong beat count, bytes shifted out of place, or a misplaced tlast. A fault in the checksum parity or range shows only in the two stuffed bytes, so several frames with odd starts, odd lengths and out-of-range stuff positions are compared byte by byte against a model. Framing faults show as missing or extra frame_err pulses and, within a few cycles, as memory reads for a descriptor that should have been dropped.

// File: rtl/txa_pkg.sv
package txa_pkg;

    localparam int CTRL_W   = 64;
    localparam int LEN_W    = 15;
    localparam int CSOFF_W  = 6;
    localparam int STUFF_W  = 8;

    // Decoded view of the fields the assembler uses
    typedef struct packed {
        logic [LEN_W-1:0]   len;
        logic [CSOFF_W-1:0] cs_start;
        logic [STUFF_W-1:0] cs_stuff;
        logic               cs_en;
        logic               eof;
        logic               sof;
        logic               irq_req;
        logic               no_crc;
    } txa_ctrl_t;

    typedef enum logic [2:0] {
        S_IDLE,
        S_FETCH,
        S_DONE,
        S_INS_HI,
        S_INS_LO,
        S_SEND
    } txa_state_e;

    function automatic txa_ctrl_t txa_decode(input logic [33:0] w);
        txa_ctrl_t c;
        c.len      = w[14:0];
        c.cs_start = w[20:15];
        c.cs_stuff = w[28:21];
        c.cs_en    = w[29];
        c.eof      = w[30];
        c.sof      = w[31];
        c.irq_req  = w[32];
        c.no_crc   = w[33];
        return c;
    endfunction

    // Two end-around-carry folds bring a 32-bit sum into 16 bits
    function automatic logic [15:0] txa_fold(input logic [31:0] s);
        logic [16:0] t;
        logic [16:0] r;
        t = {1'b0, s[15:0]} + {1'b0, s[31:16]};
        r = {1'b0, t[15:0]} + {16'd0, t[16]};
        return r[15:0];
    endfunction

endpackage

// File: rtl/txa_fetch.sv
module txa_fetch #(
    parameter int ADDR_W = 64,
    parameter int LEN_W  = 15
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] base,
    input  logic [LEN_W-1:0]  len,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_valid,
    input  logic [7:0]        rd_data,
    output logic              byte_valid,
    output logic [7:0]        byte_data,
    output logic              byte_last
);

    logic [ADDR_W-1:0] addr_q;
    logic [LEN_W-1:0]  remain_q;
    logic              pend_q;
    logic              busy;

    assign busy       = (remain_q != '0);
    assign rd_en      = busy && !pend_q;
    assign rd_addr    = addr_q;
    assign byte_valid = rd_valid && pend_q;
    assign byte_data  = rd_data;
    assign byte_last  = byte_valid && (remain_q == LEN_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q   <= '0;
            remain_q <= '0;
            pend_q   <= 1'b0;
        end else if (start) begin
            addr_q   <= base;
            remain_q <= len;
            pend_q   <= 1'b0;
        end else begin
            if (rd_en) begin
                pend_q <= 1'b1;
            end
            if (byte_valid) begin
                pend_q   <= 1'b0;
                addr_q   <= addr_q + ADDR_W'(1);
                remain_q <= remain_q - LEN_W'(1);
            end
        end
    end

endmodule

// File: rtl/txa_csum.sv
module txa_csum #(
    parameter int ACC_W = 32
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        clr,
    input  logic        acc_en,
    input  logic        hi_byte,
    input  logic [7:0]  data,
    output logic [15:0] cs_out
);
    import txa_pkg::*;

    logic [ACC_W-1:0] sum_q;
    logic [15:0]      word;

    assign word   = hi_byte ? {data, 8'h00} : {8'h00, data};
    assign cs_out = ~txa_fold(32'(sum_q));

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            sum_q <= '0;
        end else if (acc_en) begin
            sum_q <= sum_q + ACC_W'(word);
        end
    end

endmodule

// File: rtl/txa_framebuf.sv
module txa_framebuf #(
    parameter int DEPTH = 2048,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);

    logic [7:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            store[waddr] <= wdata;
        end
    end

    assign rdata = store[raddr];

endmodule

// File: rtl/txd_frame_asm.sv
module txd_frame_asm
    import txa_pkg::*;
#(
    parameter int ADDR_W    = 64,
    parameter int FRAME_MAX = 2048
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              desc_valid,
    output logic              desc_ready,
    input  logic [63:0]       desc_ctrl,
    input  logic [ADDR_W-1:0] desc_addr,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic              mem_rd_valid,
    input  logic [7:0]        mem_rd_data,
    output logic              m_axis_tvalid,
    input  logic              m_axis_tready,
    output logic [7:0]        m_axis_tdata,
    output logic              m_axis_tlast,
    output logic              m_axis_tuser,
    output logic              irq,
    output logic              frame_err
);

    localparam int AW    = $clog2(FRAME_MAX);
    localparam int PTR_W = AW + 1;
    localparam logic [PTR_W-1:0] FMAX_P = PTR_W'(FRAME_MAX);

    txa_ctrl_t  dec;
    txa_state_e state_q;

    logic               open_q;
    logic               cs_en_q;
    logic [CSOFF_W-1:0] cs_start_q;
    logic [STUFF_W-1:0] cs_stuff_q;
    logic               no_crc_q;
    logic               eof_q;
    logic               irq_req_q;
    logic               irq_q;
    logic               err_q;
    logic [PTR_W-1:0]   wr_ptr_q;
    logic [PTR_W-1:0]   rd_ptr_q;

    logic               unused_ctrl_hi;
    logic               desc_fire;
    logic               desc_bad;
    logic               fetch_start;
    logic               cs_clr;
    logic               cs_acc;
    logic               cs_hi;
    logic               room;
    logic               in_range;
    logic [15:0]        cs_val;
    logic [PTR_W-1:0]   stuff_hi;
    logic [PTR_W-1:0]   stuff_lo;

    logic               f_valid;
    logic [7:0]         f_data;
    logic               f_last;

    logic               buf_we;
    logic [AW-1:0]      buf_waddr;
    logic [7:0]         buf_wdata;
    logic [7:0]         buf_rdata;
    logic               send_last;

    assign unused_ctrl_hi = ^desc_ctrl[63:34];
    assign dec            = txa_decode(desc_ctrl[33:0]);

    // Descriptor intake and framing check
    assign desc_ready  = (state_q == S_IDLE);
    assign desc_fire   = desc_valid && desc_ready;
    assign desc_bad    = (dec.sof == open_q);
    assign fetch_start = desc_fire && !desc_bad && (dec.len != '0);
    assign cs_clr      = desc_fire && !desc_bad && dec.sof;

    // Byte placement and checksum range
    assign room     = (wr_ptr_q < FMAX_P);
    assign in_range = (wr_ptr_q >= PTR_W'(cs_start_q));
    assign cs_hi    = ~(wr_ptr_q[0] ^ cs_start_q[0]);
    assign cs_acc   = (state_q == S_FETCH) && f_valid && room && cs_en_q && in_range;
    assign stuff_hi = PTR_W'(cs_stuff_q);
    assign stuff_lo = PTR_W'(cs_stuff_q) + PTR_W'(1);

    txa_fetch #(
        .ADDR_W (ADDR_W),
        .LEN_W  (LEN_W)
    ) u_fetch (
        .clk        (clk),
        .rst        (rst),
        .start      (fetch_start),
        .base       (desc_addr),
        .len        (dec.len),
        .rd_en      (mem_rd_en),
        .rd_addr    (mem_rd_addr),
        .rd_valid   (mem_rd_valid),
        .rd_data    (mem_rd_data),
        .byte_valid (f_valid),
        .byte_data  (f_data),
        .byte_last  (f_last)
    );

    txa_csum #(
        .ACC_W (32)
    ) u_csum (
        .clk     (clk),
        .rst     (rst),
        .clr     (cs_clr),
        .acc_en  (cs_acc),
        .hi_byte (cs_hi),
        .data    (f_data),
        .cs_out  (cs_val)
    );

    // Write port shared by fetched bytes and the two stuffed bytes
    always_comb begin
        buf_we    = 1'b0;
        buf_waddr = wr_ptr_q[AW-1:0];
        buf_wdata = f_data;
        case (state_q)
            S_FETCH: begin
                buf_we = f_valid && room;
            end
            S_INS_HI: begin
                buf_we    = (stuff_hi < wr_ptr_q);
                buf_waddr = stuff_hi[AW-1:0];
                buf_wdata = cs_val[15:8];
            end
            S_INS_LO: begin
                buf_we    = (stuff_lo < wr_ptr_q);
                buf_waddr = stuff_lo[AW-1:0];
                buf_wdata = cs_val[7:0];
            end
            default: begin
                buf_we = 1'b0;
            end
        endcase
    end

    txa_framebuf #(
        .DEPTH (FRAME_MAX)
    ) u_buf (
        .clk   (clk),
        .we    (buf_we),
        .waddr (buf_waddr),
        .wdata (buf_wdata),
        .raddr (rd_ptr_q[AW-1:0]),
        .rdata (buf_rdata)
    );

    // Output stream
    assign send_last     = (rd_ptr_q == (wr_ptr_q - PTR_W'(1)));
    assign m_axis_tvalid = (state_q == S_SEND);
    assign m_axis_tdata  = buf_rdata;
    assign m_axis_tlast  = (state_q == S_SEND) && send_last;
    assign m_axis_tuser  = (state_q == S_SEND) && no_crc_q;
    assign irq           = irq_q;
    assign frame_err     = err_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= S_IDLE;
            open_q     <= 1'b0;
            cs_en_q    <= 1'b0;
            cs_start_q <= '0;
            cs_stuff_q <= '0;
            no_crc_q   <= 1'b0;
            eof_q      <= 1'b0;
            irq_req_q  <= 1'b0;
            irq_q      <= 1'b0;
            err_q      <= 1'b0;
            wr_ptr_q   <= '0;
            rd_ptr_q   <= '0;
        end else begin
            irq_q <= 1'b0;
            err_q <= 1'b0;
            case (state_q)
                S_IDLE: begin
                    if (desc_fire) begin
                        if (desc_bad) begin
                            err_q <= 1'b1;
                        end else begin
                            if (dec.sof) begin
                                cs_en_q    <= dec.cs_en;
                                cs_start_q <= dec.cs_start;
                                cs_stuff_q <= dec.cs_stuff;
                                no_crc_q   <= dec.no_crc;
                                wr_ptr_q   <= '0;
                            end
                            open_q    <= 1'b1;
                            eof_q     <= dec.eof;
                            irq_req_q <= dec.irq_req;
                            state_q   <= (dec.len != '0) ? S_FETCH : S_DONE;
                        end
                    end
                end
                S_FETCH: begin
                    if (f_valid) begin
                        if (room) begin
                            wr_ptr_q <= wr_ptr_q + PTR_W'(1);
                        end
                        if (f_last) begin
                            state_q <= S_DONE;
                        end
                    end
                end
                S_DONE: begin
                    irq_q <= irq_req_q;
                    if (eof_q) begin
                        open_q   <= 1'b0;
                        rd_ptr_q <= '0;
                        if (wr_ptr_q == '0) begin
                            state_q <= S_IDLE;
                        end else if (cs_en_q) begin
                            state_q <= S_INS_HI;
                        end else begin
                            state_q <= S_SEND;
                        end
                    end else begin
                        state_q <= S_IDLE;
                    end
                end
                S_INS_HI: begin
                    state_q <= S_INS_LO;
                end
                S_INS_LO: begin
                    state_q <= S_SEND;
                end
                S_SEND: begin
                    if (m_axis_tready) begin
                        if (send_last) begin
                            state_q <= S_IDLE;
                        end else begin
                            rd_ptr_q <= rd_ptr_q + PTR_W'(1);
                        end
                    end
                end
                default: begin
                    state_q <= S_IDLE;
                end
            endcase
        end
    end

endmodule

// File: rtl/txa_chk.sv
module txa_chk (
    input logic       clk,
    input logic       rst,
    input logic       desc_ready,
    input logic       mem_rd_en,
    input logic       m_axis_tvalid,
    input logic       m_axis_tready,
    input logic [7:0] m_axis_tdata,
    input logic       m_axis_tlast,
    input logic       m_axis_tuser,
    input logic       irq,
    input logic       frame_err
);

    AST_AXIS_HOLD: assert property (@(posedge clk) disable iff (rst)
        (m_axis_tvalid && !m_axis_tready) |=> (m_axis_tvalid && $stable(m_axis_tdata)
            && $stable(m_axis_tlast) && $stable(m_axis_tuser)));                          // R9

    AST_NO_INTAKE_WHILE_SENDING: assert property (@(posedge clk) disable iff (rst)
        m_axis_tvalid |-> !desc_ready);                                                   // R9

    AST_LAST_IN_BEAT: assert property (@(posedge clk) disable iff (rst)
        m_axis_tlast |-> m_axis_tvalid);                                                  // R1

    AST_USER_STEADY: assert property (@(posedge clk) disable iff (rst)
        (m_axis_tvalid && $past(m_axis_tvalid)) |-> $stable(m_axis_tuser));               // R6

    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq);                                                                    // R5

    AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (rst)
        mem_rd_en |=> !mem_rd_en);                                                        // R11

    AST_ERR_NO_READ: assert property (@(posedge clk) disable iff (rst)
        frame_err |-> !mem_rd_en);                                                        // R7

endmodule

bind txd_frame_asm txa_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .desc_ready    (desc_ready),
    .mem_rd_en     (mem_rd_en),
    .m_axis_tvalid (m_axis_tvalid),
    .m_axis_tready (m_axis_tready),
    .m_axis_tdata  (m_axis_tdata),
    .m_axis_tlast  (m_axis_tlast),
    .m_axis_tuser  (m_axis_tuser),
    .irq           (irq),
    .frame_err     (frame_err)
);

// File: tb/tb_txd_frame_asm.sv
`timescale 1ns/1ps
module tb_txd_frame_asm;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        desc_valid = 1'b0;
    logic        desc_ready;
    logic [63:0] desc_ctrl = '0;
    logic [63:0] desc_addr = '0;
    logic        mem_rd_en;
    logic [63:0] mem_rd_addr;
    logic        mem_rd_valid;
    logic [7:0]  mem_rd_data;
    logic        m_axis_tvalid;
    logic        m_axis_tready;
    logic [7:0]  m_axis_tdata;
    logic        m_axis_tlast;
    logic        m_axis_tuser;
    logic        irq;
    logic        frame_err;

    always #2.5 clk = ~clk;

    txd_frame_asm dut (
        .clk           (clk),
        .rst           (rst),
        .desc_valid    (desc_valid),
        .desc_ready    (desc_ready),
        .desc_ctrl     (desc_ctrl),
        .desc_addr     (desc_addr),
        .mem_rd_en     (mem_rd_en),
        .mem_rd_addr   (mem_rd_addr),
        .mem_rd_valid  (mem_rd_valid),
        .mem_rd_data   (mem_rd_data),
        .m_axis_tvalid (m_axis_tvalid),
        .m_axis_tready (m_axis_tready),
        .m_axis_tdata  (m_axis_tdata),
        .m_axis_tlast  (m_axis_tlast),
        .m_axis_tuser  (m_axis_tuser),
        .irq           (irq),
        .frame_err     (frame_err)
    );

    int checks = 0;
    int errors = 0;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Memory model: byte content is a function of address, one-cycle latency
    function automatic logic [7:0] mbyte(input logic [63:0] a);
        return 8'((a[7:0] * 8'd7) + a[15:8] + 8'h35);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            mem_rd_valid <= 1'b0;
            mem_rd_data  <= 8'h00;
        end else begin
            mem_rd_valid <= mem_rd_en;
            mem_rd_data  <= mbyte(mem_rd_addr);
        end
    end

    // Sink with optional pseudo-random back-pressure
    logic        bp = 1'b0;
    logic [15:0] lfsr = 16'hACE1;
    always @(posedge clk) begin
        lfsr          <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        m_axis_tready <= bp ? lfsr[0] : 1'b1;
    end

    // Observation at the falling edge
    logic [7:0] cap  [0:8191];
    logic       capu [0:8191];
    logic       capl [0:8191];
    int cap_n   = 0;
    int irq_cnt = 0;
    int err_cnt = 0;
    int rd_cnt  = 0;

    always @(negedge clk) begin
        if (!rst) begin
            if (m_axis_tvalid && m_axis_tready) begin
                cap[cap_n]  = m_axis_tdata;
                capu[cap_n] = m_axis_tuser;
                capl[cap_n] = m_axis_tlast;
                cap_n++;
            end
            if (irq)       irq_cnt++;
            if (frame_err) err_cnt++;
            if (mem_rd_en) rd_cnt++;
        end
    end

    // Expected frame model
    logic [7:0] exp_b [0:4095];
    int exp_n = 0;
    int total_reads = 0;

    task automatic add_bytes(input logic [63:0] addr, input int len);
        for (int i = 0; i < len; i++) begin
            exp_b[exp_n + i] = mbyte(addr + 64'(i));
        end
        exp_n += len;
    endtask

    task automatic apply_cs(input int cst, input int stf);
        int unsigned sum;
        logic [15:0] cs;
        sum = 0;
        for (int i = cst; i < exp_n; i++) begin
            if (((i - cst) % 2) == 0) sum += {24'd0, exp_b[i]} << 8;
            else                      sum += {24'd0, exp_b[i]};
        end
        while ((sum >> 16) != 0) sum = (sum & 32'hFFFF) + (sum >> 16);
        cs = ~sum[15:0];
        if (stf < exp_n)     exp_b[stf]     = cs[15:8];
        if (stf + 1 < exp_n) exp_b[stf + 1] = cs[7:0];
    endtask

    function automatic logic [63:0] mk(input int len, input int cst, input int stf, input bit cen,
                                       input bit eof, input bit sof, input bit iq, input bit nc);
        logic [63:0] w;
        w        = '0;
        w[14:0]  = 15'(len);
        w[20:15] = 6'(cst);
        w[28:21] = 8'(stf);
        w[29]    = cen;
        w[30]    = eof;
        w[31]    = sof;
        w[32]    = iq;
        w[33]    = nc;
        return w;
    endfunction

    task automatic send_desc(input logic [63:0] ctrl, input logic [63:0] addr);
        @(negedge clk);
        desc_ctrl  = ctrl;
        desc_addr  = addr;
        desc_valid = 1'b1;
        while (!desc_ready) @(negedge clk);
        @(negedge clk);
        desc_valid = 1'b0;
    endtask

    task automatic wait_out(input int n);
        int t;
        t = 0;
        while (cap_n < n && t < 20000) begin
            @(negedge clk);
            t++;
        end
        repeat (6) @(negedge clk);
    endtask

    task automatic check_frame(input int base, input bit user, input string req);
        int bad_d;
        int bad_u;
        int bad_l;
        int first_i;
        bad_d = 0; bad_u = 0; bad_l = 0; first_i = -1;
        chk(cap_n - base == exp_n, "R1", "frame length", cap_n - base, exp_n);
        for (int i = 0; i < exp_n && base + i < cap_n; i++) begin
            if (cap[base + i] !== exp_b[i]) begin
                if (first_i < 0) first_i = i;
                bad_d++;
            end
            if (capu[base + i] !== user) bad_u++;
            if (capl[base + i] !== (i == exp_n - 1)) bad_l++;
        end
        if (first_i >= 0)
            chk(1'b0, req, $sformatf("byte %0d", first_i), int'(cap[base + first_i]), int'(exp_b[first_i]));
        else
            chk(1'b1, req, "bytes", 0, 0);
        chk(bad_u == 0, "R6", "tuser mismatches", bad_u, 0);
        chk(bad_l == 0, "R1", "tlast mismatches", bad_l, 0);
    endtask

    typedef struct packed {
        logic [11:0] len;
        logic [15:0] addr;
        logic        cen;
        logic [5:0]  cst;
        logic [7:0]  stf;
        logic        nc;
        logic        iq;
        logic        bpe;
    } vec_t;

    localparam int NVEC = 7;
    localparam vec_t TBL [NVEC] = '{
        '{12'd20, 16'h0100, 1'b1, 6'd2,  8'd4,  1'b0, 1'b1, 1'b0},
        '{12'd33, 16'h0237, 1'b1, 6'd5,  8'd10, 1'b1, 1'b0, 1'b1},
        '{12'd16, 16'h0400, 1'b0, 6'd1,  8'd3,  1'b0, 1'b0, 1'b0},
        '{12'd12, 16'h0500, 1'b1, 6'd0,  8'd11, 1'b0, 1'b1, 1'b0},
        '{12'd8,  16'h0600, 1'b1, 6'd3,  8'd40, 1'b1, 1'b0, 1'b1},
        '{12'd64, 16'h0FC0, 1'b1, 6'd63, 8'd0,  1'b1, 1'b1, 1'b1},
        '{12'd1,  16'h0010, 1'b0, 6'd0,  8'd0,  1'b0, 1'b0, 1'b0}
    };

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        string reqs [NVEC];
        int base;
        int i0;
        int e0;
        int r0;
        reqs = '{"R3", "R9", "R1", "R4", "R4", "R3", "R1"};

        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10: idle outputs after reset
        chk(m_axis_tvalid == 1'b0, "R10", "tvalid", m_axis_tvalid, 0);
        chk(desc_ready == 1'b1,    "R10", "desc_ready", desc_ready, 1);
        chk(irq == 1'b0,           "R10", "irq", irq, 0);
        chk(frame_err == 1'b0,     "R10", "frame_err", frame_err, 0);
        chk(mem_rd_en == 1'b0,     "R10", "mem_rd_en", mem_rd_en, 0);

        // Table of single-descriptor frames
        for (int k = 0; k < NVEC; k++) begin
            vec_t v;
            v  = TBL[k];
            bp = v.bpe;
            exp_n = 0;
            add_bytes(64'(v.addr), int'(v.len));
            if (v.cen) apply_cs(int'(v.cst), int'(v.stf));
            base = cap_n;
            i0   = irq_cnt;
            send_desc(mk(int'(v.len), int'(v.cst), int'(v.stf), v.cen, 1'b1, 1'b1, v.iq, v.nc), 64'(v.addr));
            total_reads += int'(v.len);
            wait_out(base + exp_n);
            check_frame(base, v.nc, reqs[k]);
            chk(irq_cnt - i0 == int'(v.iq), "R5", "irq pulses", irq_cnt - i0, int'(v.iq));
        end
        bp = 1'b0;

        // R2 and R8: three descriptors, middle one empty, checksum across buffers
        exp_n = 0;
        add_bytes(64'h0800, 7);
        add_bytes(64'h0A00, 10);
        apply_cs(3, 1);
        base = cap_n;
        i0   = irq_cnt;
        send_desc(mk(7, 3, 1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0), 64'h0800);
        send_desc(mk(0, 0, 0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0), 64'h0000);
        send_desc(mk(10, 0, 0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1), 64'h0A00);
        total_reads += 17;
        wait_out(base + exp_n);
        check_frame(base, 1'b0, "R2");
        chk(irq_cnt - i0 == 2, "R5", "irq pulses multi", irq_cnt - i0, 2);

        // R8: frame made only of empty descriptors
        base = cap_n;
        e0   = err_cnt;
        r0   = rd_cnt;
        send_desc(mk(0, 0, 0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0), 64'h0);
        send_desc(mk(0, 0, 0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0), 64'h0);
        repeat (30) @(negedge clk);
        chk(cap_n == base,  "R8", "beats for empty frame", cap_n - base, 0);
        chk(err_cnt == e0,  "R8", "errors for empty frame", err_cnt - e0, 0);
        chk(rd_cnt == r0,   "R8", "reads for empty frame", rd_cnt - r0, 0);

        // R7: continuation while no frame is open
        e0 = err_cnt;
        r0 = rd_cnt;
        send_desc(mk(5, 0, 0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0), 64'h0100);
        repeat (30) @(negedge clk);
        chk(err_cnt - e0 == 1, "R7", "error pulses orphan", err_cnt - e0, 1);
        chk(rd_cnt == r0,      "R7", "reads for orphan", rd_cnt - r0, 0);
        chk(cap_n == base,     "R7", "beats for orphan", cap_n - base, 0);

        // R7: second start inside an open frame is dropped, frame continues
        exp_n = 0;
        add_bytes(64'h1000, 6);
        add_bytes(64'h1100, 5);
        e0 = err_cnt;
        i0 = irq_cnt;
        send_desc(mk(6, 0, 0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1), 64'h1000);
        send_desc(mk(9, 0, 0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0), 64'h2000);
        send_desc(mk(5, 0, 0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0), 64'h1100);
        total_reads += 11;
        wait_out(base + exp_n);
        check_frame(base, 1'b1, "R7");
        chk(err_cnt - e0 == 1, "R7", "error pulses nested start", err_cnt - e0, 1);
        chk(irq_cnt == i0,     "R7", "irq from dropped descriptor", irq_cnt - i0, 0);

        // R11: one read per byte of accepted descriptors
        chk(rd_cnt == total_reads, "R11", "memory reads", rd_cnt, total_reads);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule